// File: doc/BRIEF.md
# Busy-Aware Serial Host Engine

This block is a serial peripheral master that runs one complete transfer to a single addressed slave. After a start command it pulls chip select low and sends an address byte made of a fixed 7-bit slave address and a direction bit. It then either sends or receives a programmed number of 32-bit words. Bits travel most significant first. The serial clock idles low, and each bit is valid at the rising edge (mode 0).

The slave may pull an out-of-band busy line low when it cannot take more traffic. The host synchronizes that line and checks it only at byte boundaries. While it is low, the host parks with the clock low and chip select held. When the line returns high, the host continues with the next byte, so no data is repeated or dropped. Words to send are taken from a word input, with a one-cycle take strobe for each word. Received words appear on a word output with a one-cycle valid strobe. A done pulse marks the end of the transfer.

Top module: `spiBusyHost`

## Requirements
- R1: After reset, chip select is high (deasserted), the serial clock is low, and done and read-valid are low.
- R2: The serial clock idles low. Each transfer carries exactly 8*(1+4*N) clock pulses for a word count N, with data driven while the clock is low.
- R3: The first byte after chip select falls is {7'b1000000, dir}, sent MSB first: 0x80 when rdNotWr=0 (write) and 0x81 when rdNotWr=1 (read).
- R4: In a write, wrTake pulses once per word, before that word's first bit. The word present on wrWord in that cycle is sent MSB first.
- R5: In a read, miso is sampled at each rising clock edge. After every fourth data byte, rdValid pulses for one cycle with the 32-bit word assembled MSB first.
- R6: In a read, mosi stays low for every bit after the address byte.
- R7: If the synchronized busyN is low at a byte boundary, the clock stays low and chip select stays low with no bits moved. When busyN returns high, the transfer resumes with the next byte and the data is intact.
- R8: busyN is acted on only at byte boundaries. A pause always leaves a multiple of 8 bits transferred, including a pause requested before start, which stops after the address byte.
- R9: done pulses for exactly one cycle after the last bit, while chip select is still low. Chip select rises no sooner than one full serial clock period (2*CLK_HALF system cycles) after done.
- R10: A start pulse during a transfer is ignored. Direction, word count and the single done pulse all follow the original command.
- R11: A word count of 0 sends only the address byte, then ends with done.
- R12: The serial clock is high only while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (used only when idle) |
| rdNotWr | input | 1 | Direction: 1 read, 0 write |
| wordCount | input | CNT_W | Number of 32-bit words in the payload |
| wrWord | input | WORD_W | Word to send, taken when wrTake is high |
| wrTake | output | 1 | One-cycle strobe: wrWord is consumed |
| rdWord | output | WORD_W | Last received word |
| rdValid | output | 1 | One-cycle strobe: rdWord is new |
| done | output | 1 | One-cycle pulse at end of transfer |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave |
| csN | output | 1 | Active-low chip select |
| busyN | input | 1 | Slave ready; low requests a pause |

## Verification
The embedded assertions check on every cycle that the clock never runs without chip select, and that a parked boundary with busy low holds the clock low and chip select asserted. They also check that the control only reaches a boundary with a whole byte counted, that done is one cycle long and falls inside chip select, that mosi stays low in the read payload, and that the latched direction does not change on a stray start. Only the bench scenarios can show the content of the exchange. These cover the address byte value, the written and read words bit for bit, the total pulse count, and that a pause requested mid-byte stops at the next multiple of eight and resumes without loss. They also cover the chip-select tail length after done and that a second start leaves the transfer unchanged.

// File: rtl/spiHostPkg.sv
package spiHostPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_BOUND,
    ST_TAIL
  } hostState_t;

  typedef struct packed {
    logic loadAddr;   // place address byte in transmit register
    logic loadWord;   // place next payload word in transmit register
    logic shiftBit;   // advance transmit register after a falling edge
    logic sampleBit;  // capture miso at the rising edge
    logic emitWord;   // a full received word is ready
    logic isRead;     // latched transfer direction
    logic dataPhase;  // address byte already sent
  } ctrlStrb_t;

endpackage

// File: rtl/spiHostCtrl.sv
module spiHostCtrl
  import spiHostPkg::*;
#(
  parameter int CLK_HALF = 2,
  parameter int CNT_W    = 8,
  parameter int WORD_W   = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             rdNotWr,
  input  logic [CNT_W-1:0] wordCount,
  input  logic             busyN,
  output ctrlStrb_t        strb,
  output logic             sclk,
  output logic             csN,
  output logic             done,
  output logic             wrTake
);

  localparam int WORD_BYTES = WORD_W / 8;
  localparam int BYTE_CW    = (WORD_BYTES > 2) ? $clog2(WORD_BYTES) : 1;
  localparam int DIV_W      = $clog2(2 * CLK_HALF) + 1;
  localparam logic [DIV_W-1:0]   HALF_END  = DIV_W'(CLK_HALF - 1);
  localparam logic [DIV_W-1:0]   TAIL_END  = DIV_W'(2 * CLK_HALF - 1);
  localparam logic [BYTE_CW-1:0] LAST_BYTE = BYTE_CW'(WORD_BYTES - 1);

  hostState_t         state;
  logic [DIV_W-1:0]   divCnt;
  logic [2:0]         bitCnt;
  logic [BYTE_CW-1:0] byteCnt;
  logic [CNT_W-1:0]   wordsLeft;
  logic               addrPhase;
  logic               isRead;
  logic [1:0]         busySync;
  logic               busyOk;
  logic               divDone;

  assign busyOk  = busySync[1];
  assign divDone = (divCnt == HALF_END);

  always_comb begin
    strb           = '0;
    strb.loadAddr  = (state == ST_IDLE) && start;
    strb.sampleBit = (state == ST_LOW) && divDone;
    strb.shiftBit  = (state == ST_HIGH) && divDone;
    strb.emitWord  = (state == ST_HIGH) && divDone && (bitCnt == 3'd7) &&
                     !addrPhase && isRead && (byteCnt == LAST_BYTE);
    strb.loadWord  = (state == ST_BOUND) && (wordsLeft != '0) && busyOk &&
                     (byteCnt == '0);
    strb.isRead    = isRead;
    strb.dataPhase = !addrPhase && (state != ST_IDLE);
  end

  assign wrTake = strb.loadWord && !isRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busySync <= 2'b11;
    end else begin
      busySync <= {busySync[0], busyN};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      divCnt    <= '0;
      bitCnt    <= '0;
      byteCnt   <= '0;
      wordsLeft <= '0;
      addrPhase <= 1'b0;
      isRead    <= 1'b0;
      sclk      <= 1'b0;
      csN       <= 1'b1;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            isRead    <= rdNotWr;
            wordsLeft <= wordCount;
            addrPhase <= 1'b1;
            bitCnt    <= '0;
            byteCnt   <= '0;
            divCnt    <= '0;
            csN       <= 1'b0;
            state     <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (divDone) begin
            sclk   <= 1'b1;
            divCnt <= '0;
            state  <= ST_HIGH;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (divDone) begin
            sclk   <= 1'b0;
            divCnt <= '0;
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == 3'd7) begin
              state <= ST_BOUND;
              if (addrPhase) begin
                addrPhase <= 1'b0;
                byteCnt   <= '0;
              end else if (byteCnt == LAST_BYTE) begin
                byteCnt   <= '0;
                wordsLeft <= wordsLeft - 1'b1;
              end else begin
                byteCnt <= byteCnt + 1'b1;
              end
            end else begin
              state <= ST_LOW;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_BOUND: begin
          if (wordsLeft == '0) begin
            done   <= 1'b1;
            divCnt <= '0;
            state  <= ST_TAIL;
          end else if (busyOk) begin
            state <= ST_LOW;
          end
        end
        ST_TAIL: begin
          if (divCnt == TAIL_END) begin
            csN   <= 1'b1;
            state <= ST_IDLE;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_sclk_needs_cs_R12: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !csN);

  assert_pause_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BOUND && !busyOk && wordsLeft != '0)
      |=> (state == ST_BOUND && !sclk && !csN));

  assert_boundary_whole_byte_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BOUND) |-> (bitCnt == 3'd0 && !sclk));

  assert_done_inside_cs_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !csN);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && $past(state) != ST_IDLE && start) |=> $stable(isRead));

endmodule

// File: rtl/spiHostData.sv
module spiHostData
  import spiHostPkg::*;
#(
  parameter int          WORD_W     = 32,
  parameter logic [6:0]  SLAVE_ADDR = 7'b1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              reqRead,
  input  logic [WORD_W-1:0] wrWord,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rdWord,
  output logic              rdValid
);

  localparam int PAD_W = WORD_W - 8;

  logic [WORD_W-1:0] txReg;
  logic [WORD_W-1:0] rxReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '0;
    end else if (strb.loadAddr) begin
      txReg <= {SLAVE_ADDR, reqRead, {PAD_W{1'b0}}};
    end else if (strb.loadWord) begin
      txReg <= strb.isRead ? '0 : wrWord;
    end else if (strb.shiftBit) begin
      txReg <= {txReg[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg   <= '0;
      rdWord  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (strb.sampleBit) rxReg <= {rxReg[WORD_W-2:0], miso};
      rdValid <= strb.emitWord;
      if (strb.emitWord) rdWord <= rxReg;
    end
  end

  assign mosi = txReg[WORD_W-1];

  assert_read_mosi_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataPhase && strb.isRead) |-> !mosi);

  assert_valid_only_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> strb.isRead);

endmodule

// File: rtl/spiBusyHost.sv
module spiBusyHost
  import spiHostPkg::*;
#(
  parameter int         CLK_HALF   = 2,
  parameter int         CNT_W      = 8,
  parameter int         WORD_W     = 32,
  parameter logic [6:0] SLAVE_ADDR = 7'b1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              rdNotWr,
  input  logic [CNT_W-1:0]  wordCount,
  input  logic [WORD_W-1:0] wrWord,
  output logic              wrTake,
  output logic [WORD_W-1:0] rdWord,
  output logic              rdValid,
  output logic              done,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              csN,
  input  logic              busyN
);

  ctrlStrb_t strb;

  spiHostCtrl #(
    .CLK_HALF(CLK_HALF),
    .CNT_W   (CNT_W),
    .WORD_W  (WORD_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .rdNotWr  (rdNotWr),
    .wordCount(wordCount),
    .busyN    (busyN),
    .strb     (strb),
    .sclk     (sclk),
    .csN      (csN),
    .done     (done),
    .wrTake   (wrTake)
  );

  spiHostData #(
    .WORD_W    (WORD_W),
    .SLAVE_ADDR(SLAVE_ADDR)
  ) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .reqRead(rdNotWr),
    .wrWord (wrWord),
    .miso   (miso),
    .mosi   (mosi),
    .rdWord (rdWord),
    .rdValid(rdValid)
  );

endmodule

// File: tb/spiBusyHost_tb.sv
module spiBusyHost_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int CNT_W      = 8;
  localparam int WORD_W     = 32;
  localparam int MAXB       = 512;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic              rdNotWr = 1'b0;
  logic [CNT_W-1:0]  wordCount = '0;
  logic [WORD_W-1:0] wrWord;
  logic              wrTake;
  logic [WORD_W-1:0] rdWord;
  logic              rdValid;
  logic              done;
  logic              sclk;
  logic              mosi;
  logic              miso;
  logic              csN;
  logic              busyN = 1'b1;

  int errCnt = 0;
  int chkCnt = 0;
  logic clrStats = 1'b0;

  int   rxBits = 0;
  logic capBits [MAXB];
  int   wordIdx = 0;
  int   wrTakes = 0;
  int   rdCnt = 0;
  int   doneCnt = 0;
  int   sclkViol = 0;
  logic [WORD_W-1:0] rdWords [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] wrPattern(input int i);
    return 32'hC3A5_0F96 ^ (32'(i) * 32'h1357_9BDF);
  endfunction

  function automatic logic [31:0] rdPattern(input int i);
    return 32'h5A3C_96E1 + 32'(i) * 32'h0102_0408;
  endfunction

  function automatic logic misoBit(input int k);
    logic [31:0] w;
    if (k < 8) return 1'b0;
    w = rdPattern((k - 8) / 32);
    return w[31 - ((k - 8) % 32)];
  endfunction

  assign wrWord = wrPattern(wordIdx);
  assign miso   = misoBit(rxBits);

  spiBusyHost #(.CLK_HALF(HALF), .CNT_W(CNT_W), .WORD_W(WORD_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .rdNotWr(rdNotWr),
    .wordCount(wordCount), .wrWord(wrWord), .wrTake(wrTake),
    .rdWord(rdWord), .rdValid(rdValid), .done(done), .sclk(sclk),
    .mosi(mosi), .miso(miso), .csN(csN), .busyN(busyN)
  );

  // slave model: capture at rising edge, restart count when selected
  always @(posedge sclk or negedge csN) begin
    if (!sclk) begin
      rxBits <= 0;
    end else begin
      if (rxBits < MAXB) capBits[rxBits] <= mosi;
      rxBits <= rxBits + 1;
    end
  end

  always @(posedge clk) begin
    if (clrStats) begin
      wordIdx <= 0; wrTakes <= 0; rdCnt <= 0; doneCnt <= 0;
    end else begin
      if (wrTake) begin wordIdx <= wordIdx + 1; wrTakes <= wrTakes + 1; end
      if (rdValid) begin
        if (rdCnt < 8) rdWords[rdCnt] <= rdWord;
        rdCnt <= rdCnt + 1;
      end
      if (done) doneCnt <= doneCnt + 1;
    end
  end

  always @(negedge clk) if (sclk && csN) sclkViol <= sclkViol + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit rd, input int n, input int busyAt, input bit intrude);
    int cyc;
    int k;
    bit pauseDone;
    bit poked;
    int stopExp;
    int bad;
    logic [7:0] addrByte;
    clrStats = 1'b1;
    @(negedge clk);
    clrStats = 1'b0;
    pauseDone = (busyAt < 0);
    poked = !intrude;
    stopExp = (busyAt <= 0) ? 8 : ((busyAt + 7) / 8) * 8;
    if (busyAt == 0) busyN = 1'b0;
    rdNotWr = rd; wordCount = CNT_W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0; rdNotWr = !rd; wordCount = CNT_W'(n + 1);
    cyc = 0;
    while (!done && cyc < 20000) begin
      if (!pauseDone && rxBits >= busyAt && (busyAt > 0 || rxBits >= 8)) begin
        if (busyAt > 0) busyN = 1'b0;
        repeat (150) @(negedge clk);
        // R8: a pause always lands on a byte boundary
        chk(rxBits == stopExp, "R8 pause bit count", rxBits, stopExp);
        // R7: parked with clock low and chip select held
        chk(!sclk && !csN, "R7 parked lines", {sclk, csN}, 0);
        busyN = 1'b1;
        pauseDone = 1'b1;
      end
      if (!poked && rxBits == 12) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        poked = 1'b1;
      end
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, "R9 done seen", done, 1);
    chk(!csN, "R9 cs low at done", csN, 0);
    k = 0;
    while (!csN && k < 100) begin @(negedge clk); k++; end
    chk(k >= 2 * HALF, "R9 cs tail length", k, 2 * HALF);
    chk(rxBits == 8 * (1 + 4 * n), (n == 0) ? "R11 address only" : "R2 pulse count",
        rxBits, 8 * (1 + 4 * n));
    addrByte = '0;
    for (int i = 0; i < 8; i++) addrByte = {addrByte[6:0], capBits[i]};
    chk(addrByte == {7'b1000000, rd}, "R3 address byte", addrByte, {7'b1000000, rd});
    bad = 0;
    if (!rd) begin
      for (int w = 0; w < n; w++) begin
        logic [31:0] ew;
        ew = wrPattern(w);
        for (int b = 0; b < 32; b++) if (capBits[8 + 32 * w + b] !== ew[31 - b]) bad++;
      end
      chk(bad == 0, "R4 written bits", bad, 0);
      chk(wrTakes == n, "R4 take count", wrTakes, n);
    end else begin
      for (int b = 8; b < 8 + 32 * n; b++) if (capBits[b] !== 1'b0) bad++;
      chk(bad == 0, "R6 mosi low in read", bad, 0);
      chk(rdCnt == n, "R5 word count", rdCnt, n);
      for (int w = 0; w < n && w < 8; w++)
        chk(rdWords[w] == rdPattern(w), "R5 read word", rdWords[w], rdPattern(w));
      chk(wrTakes == 0, "R4 no take in read", wrTakes, 0);
    end
    chk(doneCnt == 1, intrude ? "R10 single done" : "R9 single done", doneCnt, 1);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errCnt + 1, chkCnt + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(csN && !sclk && !done && !rdValid, "R1 reset outputs",
        {csN, sclk, done, rdValid}, 4'b1000);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R2 R3 R4 R5 R6 R11: sweep both directions and small word counts
    for (int d = 0; d < 2; d++)
      for (int n = 0; n < 4; n++)
        xfer(d[0], n, -1, 1'b0);
    // R7 R8: pauses mid-byte and before start
    xfer(1'b0, 3, 20, 1'b0);
    xfer(1'b1, 2, 41, 1'b0);
    xfer(1'b0, 1, 0, 1'b0);
    xfer(1'b1, 3, 0, 1'b0);
    xfer(1'b1, 3, 70, 1'b0);
    // R10: stray start during a transfer
    xfer(1'b0, 2, -1, 1'b1);
    xfer(1'b1, 2, -1, 1'b1);
    // R12: clock never high without chip select
    chk(sclkViol == 0, "R12 clock without select", sclkViol, 0);
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule